// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block turns an asynchronous serial line into parallel words. The line is first brought into the system clock domain. A tick enable, running at sixteen times the bit rate, then paces a five-state controller. The controller waits for a falling edge on the line. It then confirms that the low level lasts half a bit, which marks the centre of the start bit. From there it steps one full bit period at a time and takes one sample per data bit. The bits are assembled least significant bit first. The final step of the frame does not look at the line: it publishes the assembled word and raises a one-clock completion strobe.

The output side acts as the valid half of a valid/ready stream, with no ready input. A serial line cannot be paused, so back-pressure is not possible. The consumer must capture `rx_data` in the cycle where `rx_valid` is high. The word remains on `rx_data` until the next frame completes, so a late reader still sees the last word, but it cannot tell whether it has already read that word. Bit-rate generation, parity, error reporting and queuing are left to neighbouring blocks.

Top module: `serial_rx_fsm`

## Requirements
- R1: While reset is active and after it is released, `rx_valid` is low and `rx_data` is all zeros until the first frame completes.
- R2: The serial input is read only through a two-flop synchroniser whose stages reset to the idle level (high). A frame may begin only when the synchronised line, sampled on tick cycles, goes from high to low.
- R3: If the synchronised line returns high before eight consecutive tick samples have been low, the event is dropped. No word is produced, and the controller goes back to waiting for a falling edge.
- R4: A low level that holds for eight tick samples is taken as a start bit, and a frame follows.
- R5: Each data bit is sampled sixteen ticks after the previous reference point: the start-bit centre for the first bit, the previous sample for each later bit. The first bit received lands in bit 0 of `rx_data`.
- R6: The word length is the parameter DATA_BITS (default 8). Once that many bits have been sampled, the next bit-centre tick goes to the stop step, not to another sample.
- R7: The stop step ignores the line level. A frame whose stop bit is low is still delivered, with its data.
- R8: `rx_valid` is high for exactly one clock per completed frame. `rx_data` changes only in the cycle where `rx_valid` rises.
- R9: Controller state and counters advance only on cycles where `rx_tick` is high. With the tick held low, line activity produces no word.
- R10: A frame whose start bit directly follows the previous stop bit, with no idle gap, is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd_async | input | 1 | Serial line, asynchronous to clk, idles high |
| rx_data | output | DATA_BITS | Last received word, LSB = first bit on the line |
| rx_valid | output | 1 | One-clock strobe marking a new word on rx_data |

## Verification
Words with contrasting bit patterns are sent: alternating bits, all zeros, all ones, single set bits at each end, and a mixed pattern. Together they separate a correct LSB-first assembly from a reversed order, from an off-by-one sample position, and from bits that are stuck. Low pulses of two lengths test the start filter: a five-tick pulse must be dropped, and a twelve-tick pulse must be accepted and read as all ones. The remaining cases cover the stop step's indifference to the line (a low stop bit), frames sent with no idle gap between them, and a whole frame sent while the tick is held off.

// File: rtl/rxfsm_pkg.sv
package rxfsm_pkg;
  typedef enum logic [2:0] {
    ST_HUNT   = 3'd0,
    ST_CENTER = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_STOP   = 3'd4
  } rx_state_e;
endpackage

// File: rtl/rxfsm_sync.sv
module rxfsm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  output logic line_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], rxd_i};
  end

  assign line_o = chain_q[STAGES-1];

  // R2: a low level can only reach the controller after the input itself was low
  a_r2_sync_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_o) |-> !$past(chain_q[0]));
endmodule

// File: rtl/rxfsm_ctrl.sv
module rxfsm_ctrl
  import rxfsm_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      line_i,
  output logic      sample_o,
  output logic      finish_o,
  output rx_state_e state_o
);
  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam int BCNT_W = $clog2(DATA_BITS + 1);
  localparam logic [TICK_W-1:0] HALF_LAST = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [TICK_W-1:0] WAIT_LAST = TICK_W'(OVERSAMPLE - 2);
  localparam logic [BCNT_W-1:0] BITS_ALL  = BCNT_W'(DATA_BITS);

  rx_state_e         state_q;
  logic [TICK_W-1:0] tcnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      last_q  <= 1'b1;
    end else if (tick_i) begin
      last_q <= line_i;
      unique case (state_q)
        ST_HUNT: begin
          if (last_q && !line_i) begin
            state_q <= ST_CENTER;
            tcnt_q  <= TICK_W'(1);
          end
        end
        ST_CENTER: begin
          if (line_i) begin
            state_q <= ST_HUNT;
          end else if (tcnt_q == HALF_LAST) begin
            state_q <= ST_WAIT;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (tcnt_q == WAIT_LAST) begin
            tcnt_q  <= '0;
            state_q <= (bcnt_q == BITS_ALL) ? ST_STOP : ST_SAMPLE;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_SAMPLE: begin
          bcnt_q  <= bcnt_q + 1'b1;
          state_q <= ST_WAIT;
        end
        ST_STOP: begin
          state_q <= ST_HUNT;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign sample_o = tick_i && (state_q == ST_SAMPLE);
  assign finish_o = tick_i && (state_q == ST_STOP);
  assign state_o  = state_q;

  // R9: nothing moves on cycles without a tick
  a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(state_q) && $stable(tcnt_q) && $stable(bcnt_q));
  // R3: a high line during centring aborts back to hunting
  a_r3_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && state_q == ST_CENTER && line_i) |=> state_q == ST_HUNT);
  // R6: the stop step is reached only with a full word collected
  a_r6_full_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> bcnt_q == BITS_ALL);
  // R6: no sample beyond the word length
  a_r6_no_extra_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAMPLE) |-> bcnt_q < BITS_ALL);
endmodule

// File: rtl/rxfsm_collect.sv
module rxfsm_collect #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_i,
  input  logic                 finish_i,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o
);
  logic [DATA_BITS-1:0] shift_q;
  logic [DATA_BITS-1:0] data_q;
  logic                 valid_q;

  generate
    if (DATA_BITS > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (sample_i) shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (sample_i) shift_q <= line_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= finish_i;
      if (finish_i) data_q <= shift_q;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R8: strobe lasts a single clock
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R8: the word only changes together with the strobe
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(data_q));
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
  import rxfsm_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_tick,
  input  logic                 rxd_async,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid
);
  logic      line_s;
  logic      sample_stb;
  logic      finish_stb;
  rx_state_e state;

  rxfsm_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd_i  (rxd_async),
    .line_o (line_s)
  );

  rxfsm_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (rx_tick),
    .line_i   (line_s),
    .sample_o (sample_stb),
    .finish_o (finish_stb),
    .state_o  (state)
  );

  rxfsm_collect #(.DATA_BITS(DATA_BITS)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_stb),
    .finish_i (finish_stb),
    .line_i   (line_s),
    .data_o   (rx_data),
    .valid_o  (rx_valid)
  );

  // R7: the stop step delivers the word whatever the line level
  a_r7_stop_delivers: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && state == ST_STOP) |=> rx_valid);
  // R4: a word is delivered only at the end of a frame
  a_r4_valid_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(state == ST_STOP));
endmodule

// File: tb/serial_rx_fsm_bench.sv
module serial_rx_fsm_bench;
  localparam int BIT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_tick;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int wide = 0;
  int cycles = 0;
  logic [7:0] hist0 = '0, hist1 = '0;
  logic       prev_valid = 1'b0;
  logic       tick_on = 1'b1;
  logic [1:0] div = '0;

  always #2.5 clk = ~clk;

  serial_rx_fsm u_serial_rx_fsm (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd_async(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) div <= div + 2'd1;
  assign rx_tick = tick_on && (div == 2'd0);

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rx_valid) begin
      pulses <= pulses + 1;
      hist1  <= hist0;
      hist0  <= rx_data;
    end
    if (rx_valid && prev_valid) wide <= wide + 1;
    prev_valid <= rx_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rxd = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop_lvl);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop_lvl;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(rx_valid == 1'b0, "R1 valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    idle(40);
    check(rx_valid == 1'b0 && pulses == 0, "R1 valid after reset", pulses, 0);
    check(rx_data == 8'h00, "R1 data after reset", rx_data, 0);
  endtask

  // R2 R5: plain frames through the synchroniser, LSB first
  task automatic t_frame(input logic [7:0] b);
    int p0 = pulses;
    send(b, 1'b1);
    idle(20);
    check(pulses == p0 + 1, "R5 one word per frame", pulses - p0, 1);
    check(hist0 == b && rx_data == b, "R5 R2 word value", hist0, b);
  endtask

  task automatic t_glitch;
    int p0 = pulses;
    logic [7:0] d0 = rx_data;
    rxd = 1'b0;
    repeat (20) @(negedge clk);
    idle(800);
    check(pulses == p0, "R3 short pulse dropped", pulses - p0, 0);
    check(rx_data == d0, "R3 word unchanged", rx_data, d0);
  endtask

  task automatic t_long_start;
    int p0 = pulses;
    rxd = 1'b0;
    repeat (48) @(negedge clk);
    idle(800);
    check(pulses == p0 + 1 && hist0 == 8'hFF, "R4 twelve-tick low accepted", hist0, 8'hFF);
  endtask

  task automatic t_stop_low;
    int p0 = pulses;
    send(8'h5A, 1'b0);
    idle(200);
    check(pulses == p0 + 1 && hist0 == 8'h5A, "R7 low stop still delivered", hist0, 8'h5A);
    t_frame(8'hC6);
  endtask

  task automatic t_back_to_back;
    int p0 = pulses;
    send(8'h3C, 1'b1);
    send(8'hC3, 1'b1);
    idle(20);
    check(pulses == p0 + 2, "R10 two words", pulses - p0, 2);
    check(hist1 == 8'h3C && hist0 == 8'hC3, "R10 word order and values",
          {hist1, hist0}, 16'h3CC3);
  endtask

  task automatic t_hold;
    int p0 = pulses;
    logic [7:0] d0 = rx_data;
    idle(300);
    check(pulses == p0 && rx_data == d0, "R8 word held while idle", rx_data, d0);
    check(wide == 0, "R8 strobe one clock", wide, 0);
  endtask

  task automatic t_no_tick;
    int p0 = pulses;
    logic [7:0] d0 = rx_data;
    tick_on = 1'b0;
    send(8'h77, 1'b1);
    idle(50);
    tick_on = 1'b1;
    idle(200);
    check(pulses == p0 && rx_data == d0, "R9 no tick no word", pulses - p0, 0);
    t_frame(8'h99);
  endtask

  initial begin
    t_reset();
    t_frame(8'hA5);
    t_frame(8'h00);
    t_frame(8'hFF);
    t_frame(8'h36);
    t_frame(8'h01);
    t_frame(8'h80);   // R6: full eight bits reach the top position
    t_glitch();
    t_long_start();
    t_stop_low();
    t_back_to_back();
    t_hold();
    t_no_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule